// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the digital mode controller of a powered-device front end. It keeps the device in one of three operating states: wake, sleep and ultra-low-power. Software or board logic moves it between them by pulling active-low control pins, which otherwise rest high. A falling edge on the sleep request pin moves the controller out of wake. The level of the ultra-low-power select pin at that edge decides which low-power state it enters. A falling edge on the wake request pin brings it back.

In wake state the step-down converter enable is high. In both low-power states the converter is off and a status LED is pulsed slowly. In ultra-low-power state a keep-alive current is also switched on and off on a long schedule, so that the upstream supply still sees a valid load. The isolation switch enable stays high in every state. The block takes one timebase tick at 4 kHz. It uses that tick directly for the LED pattern and divides it by four to get the millisecond steps of the keep-alive schedule.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the controller is in wake state: buck_en=1, iso_en=1, led_en=0, keepalive_en=0. Pins held high cause no state change.
- R2: A falling edge on sleep_req_n in wake state enters sleep if ulp_sel_n is 1, and ultra-low-power if ulp_sel_n is 0.
- R3: A falling edge on wake_req_n in sleep or ultra-low-power returns the controller to wake. In wake state it has no effect.
- R4: A falling edge on sleep_req_n in sleep or ultra-low-power state is ignored. The state does not change and the LED phase is not disturbed.
- R5: buck_en is 1 only in wake state. iso_en is 1 in all three states.
- R6: In both low-power states led_en repeats a 16-tick period. It is 1 for the first 4 ticks, counted from state entry. In wake state led_en is 0.
- R7: keepalive_en is 0 in wake and in sleep.
- R8: In ultra-low-power state keepalive_en is 1 for 87 ms, then 0 for 235 ms, repeating. One ms is 4 ticks, so the output falls after tick 348 and rises again after tick 1288.
- R9: The LED and keep-alive timers restart from zero at every entry into a low-power state.
- R10: The level of ulp_sel_n matters only at the sleep_req_n edge. Changing it in any other state has no effect.
- R11: Each pin passes through a two-flop synchronizer. The state and outputs change on the third rising clock edge after the pin is first sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_tick | input | 1 | One-cycle 4 kHz timebase pulse |
| sleep_req_n | input | 1 | Active-low sleep request (falling edge acts) |
| wake_req_n | input | 1 | Active-low wake request (falling edge acts) |
| ulp_sel_n | input | 1 | Low selects ultra-low-power on sleep request |
| buck_en | output | 1 | Step-down converter enable |
| iso_en | output | 1 | Isolation switch enable |
| led_en | output | 1 | Pulsed LED drive enable |
| keepalive_en | output | 1 | Keep-alive current enable |

## Verification
The bench checks the LED pattern on every tick over several periods. It follows the keep-alive schedule tick by tick through one full on/off cycle. If the millisecond divider or the phase limits are off by one, the edge lands one tick early or late. The bench pulses the sleep request again while in a low-power state at a point where the LED is low; a design that re-enters or restarts on that edge shows the LED high again. It re-enters ultra-low-power from the middle of an off phase, which exposes timers that keep their old phase. It also measures the synchronizer latency cycle by cycle and changes the ultra-low-power select outside a sleep edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_WAKE  = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_ULTRA = 2'd2
  } mode_e;

  localparam int unsigned PIN_SLEEP = 0;
  localparam int unsigned PIN_WAKE  = 1;
  localparam int unsigned PIN_ULP   = 2;
  localparam int unsigned PIN_COUNT = 3;
endpackage

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_async[g]};
    end

    // Pins rest high, so reset to ones to avoid a false edge at release.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign pin_sync[g] = chain_q[LAST];
  end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sleep_lvl,
  input  logic  wake_lvl,
  input  logic  ulp_lvl,
  output mode_e mode,
  output logic  lp_entry
);
  mode_e mode_q, mode_d;
  logic  sleep_prev_q, wake_prev_q;
  logic  sleep_fall, wake_fall;

  assign sleep_fall = sleep_prev_q & ~sleep_lvl;
  assign wake_fall  = wake_prev_q  & ~wake_lvl;

  always_comb begin
    mode_d   = mode_q;
    lp_entry = 1'b0;
    unique case (mode_q)
      MODE_WAKE: begin
        if (sleep_fall) begin
          mode_d   = ulp_lvl ? MODE_SLEEP : MODE_ULTRA;
          lp_entry = 1'b1;
        end
      end
      MODE_SLEEP, MODE_ULTRA: begin
        if (wake_fall) mode_d = MODE_WAKE;
      end
      default: mode_d = MODE_WAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_WAKE;
      sleep_prev_q <= 1'b1;
      wake_prev_q  <= 1'b1;
    end else begin
      mode_q       <= mode_d;
      sleep_prev_q <= sleep_lvl;
      wake_prev_q  <= wake_lvl;
    end
  end

  assign mode = mode_q;

  assert_no_lp_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLEEP) |=> (mode_q != MODE_ULTRA));
  assert_no_ulp_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ULTRA) |=> (mode_q != MODE_SLEEP));
  assert_wake_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q != MODE_WAKE) && wake_fall) |=> (mode_q == MODE_WAKE));
  assert_entry_from_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lp_entry |-> (mode_q == MODE_WAKE));
endmodule

// File: rtl/lpm_led_pulse.sv
module lpm_led_pulse #(
  parameter int unsigned PERIOD_TICKS = 16,
  parameter int unsigned HIGH_TICKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_tick,
  input  logic active,
  input  logic restart,
  output logic led_on
);
  localparam int unsigned CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(PERIOD_TICKS - 1);
  localparam logic [CW-1:0] HIGH_LIM  = CW'(HIGH_TICKS);

  logic [CW-1:0] step_q, step_d;
  logic          step_en;

  assign step_en = restart | (active & step_tick);

  always_comb begin
    step_d = step_q;
    if (restart)                step_d = '0;
    else if (step_q == LAST_STEP) step_d = '0;
    else                        step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  assign led_on = active & (step_q < HIGH_LIM);

  assert_led_step_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);
  assert_led_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_tick && !restart) |=> $stable(step_q));
endmodule

// File: rtl/lpm_keepalive.sv
module lpm_keepalive #(
  parameter int unsigned TICKS_PER_MS = 4,
  parameter int unsigned ON_MS        = 87,
  parameter int unsigned OFF_MS       = 235
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_tick,
  input  logic active,
  input  logic restart,
  output logic keep_on
);
  localparam int unsigned PW      = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int unsigned MAX_MS  = (ON_MS > OFF_MS) ? ON_MS : OFF_MS;
  localparam int unsigned MW      = $clog2(MAX_MS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_MS - 1);
  localparam logic [MW-1:0] ON_LAST  = MW'(ON_MS - 1);
  localparam logic [MW-1:0] OFF_LAST = MW'(OFF_MS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [MW-1:0] ms_q, ms_d;
  logic          phase_on_q, phase_on_d;
  logic          ms_pulse, run_en;
  logic [MW-1:0] phase_last;

  assign run_en     = restart | (active & step_tick);
  assign ms_pulse   = active & step_tick & (pre_q == PRE_LAST);
  assign phase_last = phase_on_q ? ON_LAST : OFF_LAST;

  always_comb begin
    pre_d      = pre_q;
    ms_d       = ms_q;
    phase_on_d = phase_on_q;
    if (restart) begin
      pre_d      = '0;
      ms_d       = '0;
      phase_on_d = 1'b1;
    end else begin
      pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (ms_pulse) begin
        if (ms_q == phase_last) begin
          ms_d       = '0;
          phase_on_d = ~phase_on_q;
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '0;
      ms_q       <= '0;
      phase_on_q <= 1'b1;
    end else if (run_en) begin
      pre_q      <= pre_d;
      ms_q       <= ms_d;
      phase_on_q <= phase_on_d;
    end
  end

  assign keep_on = active & phase_on_q;

  assert_ms_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= (phase_on_q ? ON_LAST : OFF_LAST));
  assert_phase_on_ms_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !ms_pulse) |=> $stable(phase_on_q));
  assert_restart_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_on_q && ms_q == '0));
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int unsigned LED_PERIOD_TICKS = 16,
  parameter int unsigned LED_HIGH_TICKS   = 4,
  parameter int unsigned TICKS_PER_MS     = 4,
  parameter int unsigned KEEP_ON_MS       = 87,
  parameter int unsigned KEEP_OFF_MS      = 235
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_tick,
  input  logic sleep_req_n,
  input  logic wake_req_n,
  input  logic ulp_sel_n,
  output logic buck_en,
  output logic iso_en,
  output logic led_en,
  output logic keepalive_en
);
  logic [PIN_COUNT-1:0] pins_raw, pins_sync;
  mode_e mode;
  logic  lp_entry;
  logic  in_low_power, in_ultra;

  assign pins_raw[PIN_SLEEP] = sleep_req_n;
  assign pins_raw[PIN_WAKE]  = wake_req_n;
  assign pins_raw[PIN_ULP]   = ulp_sel_n;

  lpm_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pins_raw),
    .pin_sync  (pins_sync)
  );

  lpm_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_lvl (pins_sync[PIN_SLEEP]),
    .wake_lvl  (pins_sync[PIN_WAKE]),
    .ulp_lvl   (pins_sync[PIN_ULP]),
    .mode      (mode),
    .lp_entry  (lp_entry)
  );

  assign in_low_power = (mode != MODE_WAKE);
  assign in_ultra     = (mode == MODE_ULTRA);

  lpm_led_pulse #(
    .PERIOD_TICKS (LED_PERIOD_TICKS),
    .HIGH_TICKS   (LED_HIGH_TICKS)
  ) u_led (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_tick (step_tick),
    .active    (in_low_power),
    .restart   (lp_entry),
    .led_on    (led_en)
  );

  lpm_keepalive #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .ON_MS        (KEEP_ON_MS),
    .OFF_MS       (KEEP_OFF_MS)
  ) u_keep (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_tick (step_tick),
    .active    (in_ultra),
    .restart   (lp_entry),
    .keep_on   (keepalive_en)
  );

  assign buck_en = (mode == MODE_WAKE);
  assign iso_en  = 1'b1;

  assert_buck_led_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    buck_en |-> !led_en);
  assert_keep_not_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    keepalive_en |-> !buck_en);
  assert_sync_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led_en) |-> !$past(buck_en) || step_tick || $past(step_tick) || $past(lp_entry));
endmodule

// File: tb/lpm_sequencer_bench.sv
module lpm_sequencer_bench;
  localparam int LED_P  = 16;
  localparam int LED_H  = 4;
  localparam int TPM    = 4;
  localparam int ON_MS  = 87;
  localparam int OFF_MS = 235;
  localparam int ON_T   = ON_MS * TPM;
  localparam int CYC_T  = (ON_MS + OFF_MS) * TPM;

  logic clk = 1'b0;
  logic rst_n;
  logic step_tick;
  logic sleep_req_n, wake_req_n, ulp_sel_n;
  logic buck_en, iso_en, led_en, keepalive_en;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lpm_sequencer u_lpm_sequencer (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
    .sleep_req_n(sleep_req_n), .wake_req_n(wake_req_n), .ulp_sel_n(ulp_sel_n),
    .buck_en(buck_en), .iso_en(iso_en), .led_en(led_en), .keepalive_en(keepalive_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    check(act === exp, req, int'(act), int'(exp));
  endtask

  task automatic tick();
    @(negedge clk) step_tick = 1'b1;
    @(negedge clk) step_tick = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk) sleep_req_n = 1'b0;
    repeat (6) @(negedge clk);
    sleep_req_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_wake();
    @(negedge clk) wake_req_n = 1'b0;
    repeat (6) @(negedge clk);
    wake_req_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_tick = 1'b0;
    sleep_req_n = 1'b1; wake_req_n = 1'b1; ulp_sel_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 buck", buck_en, 1'b1);
    chk("R1 iso", iso_en, 1'b1);
    chk("R1 led", led_en, 1'b0);
    chk("R1 keep", keepalive_en, 1'b0);

    // R11 latency: sampled low at edge 1, change at edge 3
    @(negedge clk) sleep_req_n = 1'b0;
    @(negedge clk) chk("R11 edge1", buck_en, 1'b1);
    @(negedge clk) chk("R11 edge2", buck_en, 1'b1);
    @(negedge clk) chk("R11 edge3", buck_en, 1'b0);
    sleep_req_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 sleep entry with ulp high; R5, R6, R7
    chk("R2 sleep buck", buck_en, 1'b0);
    chk("R5 iso sleep", iso_en, 1'b1);
    chk("R6 led entry", led_en, 1'b1);
    chk("R7 keep sleep", keepalive_en, 1'b0);
    for (int k = 1; k <= 3 * LED_P; k++) begin
      tick();
      chk("R6 led pattern", led_en, ((k % LED_P) < LED_H));
      chk("R7 keep sleep", keepalive_en, 1'b0);
    end
    for (int k = 1; k <= 5; k++) tick();
    chk("R6 led step5", led_en, 1'b0);

    // R4 sleep edge ignored in sleep
    pulse_sleep();
    chk("R4 led undisturbed", led_en, 1'b0);
    chk("R4 still sleep", buck_en, 1'b0);
    chk("R4 keep", keepalive_en, 1'b0);

    // R10 ulp level change in sleep has no effect
    ulp_sel_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 keep", keepalive_en, 1'b0);
    tick(); tick(); tick();
    chk("R10 keep after ticks", keepalive_en, 1'b0);
    ulp_sel_n = 1'b1;

    // R3 wake return
    pulse_wake();
    chk("R3 buck", buck_en, 1'b1);
    chk("R3 led", led_en, 1'b0);
    chk("R5 iso wake", iso_en, 1'b1);
    for (int k = 0; k < 20; k++) tick();
    chk("R6 led wake", led_en, 1'b0);
    chk("R7 keep wake", keepalive_en, 1'b0);
    pulse_wake();
    chk("R3 wake edge in wake", buck_en, 1'b1);

    // R10 ulp low in wake without sleep edge
    ulp_sel_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 wake hold", buck_en, 1'b1);

    // R2 ultra entry
    pulse_sleep();
    ulp_sel_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 ultra buck", buck_en, 1'b0);
    chk("R8 keep entry", keepalive_en, 1'b1);
    chk("R6 led ultra entry", led_en, 1'b1);
    chk("R5 iso ultra", iso_en, 1'b1);
    for (int k = 1; k <= CYC_T + 12; k++) begin
      tick();
      chk("R8 keep schedule", keepalive_en, ((k % CYC_T) < ON_T));
      if (k <= 4 * LED_P) chk("R6 led ultra", led_en, ((k % LED_P) < LED_H));
    end
    // R4 sleep edge in ultra ignored
    pulse_sleep();
    chk("R4 ultra kept", keepalive_en, 1'b1);
    chk("R4 ultra buck", buck_en, 1'b0);

    // move into off phase then leave and re-enter: R9
    for (int k = 0; k < 400; k++) tick();
    chk("R8 off phase", keepalive_en, 1'b0);
    pulse_wake();
    chk("R3 from ultra", buck_en, 1'b1);
    chk("R7 keep after wake", keepalive_en, 1'b0);
    ulp_sel_n = 1'b0;
    pulse_sleep();
    ulp_sel_n = 1'b1;
    chk("R9 keep restarted", keepalive_en, 1'b1);
    chk("R9 led restarted", led_en, 1'b1);
    for (int k = 1; k < ON_T; k++) tick();
    chk("R9 keep before drop", keepalive_en, 1'b1);
    tick();
    chk("R9 keep drop", keepalive_en, 1'b0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule